// File: doc/BRIEF.md
# Cascaded 2-1 Noise-Shaping Modulator

This block turns an 18-bit signed, oversampled audio stream into two digital streams that feed two separate converters. A second-order loop with a sign quantizer makes a one-bit stream. The negated quantization error of that loop drives a first-order loop. The first-order loop coarsely truncates its accumulator and keeps the fraction it drops as its own state. The coarse code then passes through a digital second-difference filter. When the two converter outputs are later summed at the right weights, the first loop's error cancels. Only the third-order-shaped truncation error of the second loop is left.

A sample is taken on every cycle where the clock enable is high. Both outputs are registered on that same edge. In integer terms the one-bit output stands for plus or minus 2^18. Any 18-bit input therefore lies within half of the one-bit level. The word output is a signed count of 2^17-sized steps.

Top module: `mash21_mod`

## Requirements
- R1: A cycle with `rst` high at the clock edge clears every integrator, residue and history register and sets `bit_o` to 0 and `word_o` to 0, whatever `ce` is.
- R2: On an edge with `ce` low the outputs keep their values and no state moves, so the output sequence continues as if that cycle had not happened.
- R3: On each enabled edge `bit_o` takes 1 (meaning +2^18) when the second integrator is zero or positive, and 0 (meaning -2^18) otherwise. The integrators then advance as i1 <- i1 + x - y and i2 <- i2 + i1_new - y, where y is the level just chosen.
- R4: The second loop forms u = i2 - y (the negated first-loop error), acc = u + r, code = floor(acc / 2^17), and keeps r <- acc - code*2^17, where r is the non-negative residue.
- R5: `word_o` equals code[n] - 2*code[n-1] + code[n-2]. Reset clears the code history to zero.
- R6: An input sample taken on enabled edge n first affects the outputs registered on enabled edge n+1. The first enabled edge after reset therefore always gives `bit_o`=1 and `word_o`=-2.
- R7: For any sequence of 18-bit inputs the negated error fits in 22 signed bits, and both integrators stay inside a quarter of their 26-bit range.
- R8: Over the enabled samples since reset, (+/-2^18 from `bit_o`) + `word_o`*2^17 equals the previous input plus the third difference of an error term that lies in (-2^17, 0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Sample enable at the oversampled rate |
| x_i | input | 18 | Signed input sample |
| bit_o | output | 1 | One-bit stream, 1 means +2^18 |
| word_o | output | 8 | Signed corrected word from the truncating loop |

## Verification
A wrong integrator value shows up within one or two enabled samples as a different `bit_o` pattern. A wrong residue or a wrong history register shifts `word_o` by a step on the next enabled edge. The bench compares both outputs bit-exact on every enabled edge, so any drift is reported at the first sample where it reaches a port. The third-order cancellation check integrates the combined output three times. It catches any mismatch between the two loops that keeps the ports plausible individually, and does so within a few samples.

// File: rtl/mash21_pkg.sv
package mash21_pkg;
  // Bits dropped by the second loop's truncator. Three bits of headroom leave
  // room for the fourfold growth of the second difference.
  function automatic int trunc_shift(int err_w, int out_w);
    return err_w - out_w + 3;
  endfunction

  // Second difference of three successive codes.
  function automatic int sdiff2(int now_v, int prev1, int prev2);
    return now_v - 2 * prev1 + prev2;
  endfunction
endpackage

// File: rtl/mash21_loop2.sv
module mash21_loop2 #(
  parameter int IN_W  = 18,
  parameter int INT_W = 26,
  parameter int ERR_W = 22
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ce,
  input  logic signed [IN_W-1:0]  x_i,
  output logic                    q_bit,
  output logic signed [ERR_W-1:0] neg_err,
  output logic signed [INT_W-1:0] ne_wide,
  output logic signed [INT_W-1:0] i1_st,
  output logic signed [INT_W-1:0] i2_st
);
  localparam longint LVL = 64'sd1 << IN_W;

  logic signed [INT_W-1:0] lvl_v, x_w, i1_nx, i2_nx;

  always_comb begin
    q_bit   = ~i2_st[INT_W-1];
    lvl_v   = q_bit ? INT_W'(LVL) : INT_W'(-LVL);
    x_w     = {{(INT_W-IN_W){x_i[IN_W-1]}}, x_i};
    i1_nx   = i1_st + x_w - lvl_v;
    i2_nx   = i2_st + i1_nx - lvl_v;
    ne_wide = i2_st - lvl_v;
    neg_err = ne_wide[ERR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      i1_st <= '0;
      i2_st <= '0;
    end else if (ce) begin
      i1_st <= i1_nx;
      i2_st <= i2_nx;
    end
  end
endmodule

// File: rtl/mash21_loop1.sv
module mash21_loop1 #(
  parameter int ERR_W  = 22,
  parameter int SHIFT  = 17,
  parameter int CODE_W = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ce,
  input  logic signed [ERR_W-1:0]  u_i,
  output logic signed [CODE_W-1:0] code_o
);
  logic [SHIFT-1:0]     res_q;
  logic signed [ERR_W:0] acc;

  always_comb begin
    acc    = {u_i[ERR_W-1], u_i} + {{(ERR_W+1-SHIFT){1'b0}}, res_q};
    code_o = acc[ERR_W:SHIFT];
  end

  always_ff @(posedge clk) begin
    if (rst)     res_q <= '0;
    else if (ce) res_q <= acc[SHIFT-1:0];
  end
endmodule

// File: rtl/mash21_diff2.sv
module mash21_diff2 #(
  parameter int CODE_W = 6,
  parameter int OUT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ce,
  input  logic signed [CODE_W-1:0] code_i,
  output logic signed [OUT_W-1:0]  d_o
);
  localparam int TAPS = 2;

  logic signed [CODE_W-1:0] hist [TAPS];

  always_comb d_o = OUT_W'(mash21_pkg::sdiff2(int'(code_i), int'(hist[0]), int'(hist[1])));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS; k++) hist[k] <= '0;
    end else if (ce) begin
      hist[0] <= code_i;
      for (int k = 1; k < TAPS; k++) hist[k] <= hist[k-1];
    end
  end
endmodule

// File: rtl/mash21_mod.sv
module mash21_mod #(
  parameter int IN_W  = 18,
  parameter int INT_W = 26,
  parameter int ERR_W = 22,
  parameter int OUT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ce,
  input  logic signed [IN_W-1:0]  x_i,
  output logic                    bit_o,
  output logic signed [OUT_W-1:0] word_o
);
  localparam int SHIFT  = mash21_pkg::trunc_shift(ERR_W, OUT_W);
  localparam int CODE_W = ERR_W + 1 - SHIFT;

  logic                     q_bit;
  logic signed [ERR_W-1:0]  neg_err;
  logic signed [INT_W-1:0]  ne_wide, i1_st, i2_st;
  logic signed [CODE_W-1:0] code;
  logic signed [OUT_W-1:0]  diff_w;

  mash21_loop2 #(.IN_W(IN_W), .INT_W(INT_W), .ERR_W(ERR_W)) loop2_i (
    .clk(clk), .rst(rst), .ce(ce), .x_i(x_i), .q_bit(q_bit),
    .neg_err(neg_err), .ne_wide(ne_wide), .i1_st(i1_st), .i2_st(i2_st));

  mash21_loop1 #(.ERR_W(ERR_W), .SHIFT(SHIFT), .CODE_W(CODE_W)) loop1_i (
    .clk(clk), .rst(rst), .ce(ce), .u_i(neg_err), .code_o(code));

  mash21_diff2 #(.CODE_W(CODE_W), .OUT_W(OUT_W)) diff2_i (
    .clk(clk), .rst(rst), .ce(ce), .code_i(code), .d_o(diff_w));

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_o  <= 1'b0;
      word_o <= '0;
    end else if (ce) begin
      bit_o  <= q_bit;
      word_o <= diff_w;
    end
  end
endmodule

// File: rtl/mash21_chk.sv
module mash21_chk #(
  parameter int INT_W = 26,
  parameter int ERR_W = 22,
  parameter int OUT_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    ce,
  input logic                    bit_o,
  input logic signed [OUT_W-1:0] word_o,
  input logic                    q_bit,
  input logic signed [INT_W-1:0] ne_wide,
  input logic signed [INT_W-1:0] i1_st,
  input logic signed [INT_W-1:0] i2_st
);
  localparam longint ERR_LIM = 64'sd1 << (ERR_W - 1);
  localparam longint INT_LIM = 64'sd1 << (INT_W - 2);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!bit_o && word_o == '0));

  a_r2_hold_outputs: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(bit_o) && $stable(word_o)));

  a_r3_bit_from_sign: assert property (@(posedge clk) disable iff (rst)
    ce |=> (bit_o == $past(q_bit)));

  a_r7_err_fits: assert property (@(posedge clk) disable iff (rst)
    (longint'(ne_wide) >= -ERR_LIM && longint'(ne_wide) < ERR_LIM));

  a_r7_int_headroom: assert property (@(posedge clk) disable iff (rst)
    (longint'(i1_st) > -INT_LIM && longint'(i1_st) < INT_LIM &&
     longint'(i2_st) > -INT_LIM && longint'(i2_st) < INT_LIM));
endmodule

bind mash21_mod mash21_chk #(.INT_W(INT_W), .ERR_W(ERR_W), .OUT_W(OUT_W)) chk_i (
  .clk(clk), .rst(rst), .ce(ce), .bit_o(bit_o), .word_o(word_o), .q_bit(q_bit),
  .ne_wide(ne_wide), .i1_st(i1_st), .i2_st(i2_st));

// File: tb/mash21_mod_tb_top.sv
module mash21_mod_tb_top;
  localparam longint LVL   = 64'sd1 << 18;
  localparam longint SCALE = 64'sd1 << 17;
  localparam int SEG_N = 8;
  // mode: 0 constant, 1 alternating sign, 2 ramp from -2^17, 3 constant with enable gaps
  localparam int SEG_VAL [SEG_N] = '{0, 131071, -131072, 12345, 100000, 1024, -1, 131071};
  localparam int SEG_LEN [SEG_N] = '{200, 400, 400, 300, 300, 256, 200, 300};
  localparam int SEG_MOD [SEG_N] = '{0, 0, 0, 3, 1, 2, 0, 1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0;
  logic signed [17:0] x_i = '0;
  logic bit_o;
  logic signed [7:0] word_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  longint m_i1, m_i2, m_r, m_c1, m_c2, s1, s2, s3, xprev;
  longint prev_bit, prev_word;

  always #2.5 clk = ~clk;

  mash21_mod dut_i (.clk(clk), .rst(rst), .ce(ce), .x_i(x_i), .bit_o(bit_o), .word_o(word_o));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_i1 = 0; m_i2 = 0; m_r = 0; m_c1 = 0; m_c2 = 0;
    s1 = 0; s2 = 0; s3 = 0; xprev = 0; prev_bit = 0; prev_word = 0;
  endtask

  function automatic longint floor_step(longint a);
    longint q;
    q = a / SCALE;
    if (a < 0 && q * SCALE != a) q = q - 1;
    return q;
  endfunction

  // one cycle; inputs set away from the rising edge, outputs sampled at the falling edge
  task automatic step(input int xv, input bit cev);
    longint lv, u, acc, code, eb, ew, comb;
    x_i = xv[17:0];
    ce  = cev;
    lv  = 0;
    if (cev) begin
      lv   = (m_i2 >= 0) ? LVL : -LVL;
      eb   = (m_i2 >= 0) ? 1 : 0;
      u    = m_i2 - lv;
      acc  = u + m_r;
      code = floor_step(acc);
      m_r  = acc - code * SCALE;
      ew   = code - 2 * m_c1 + m_c2;
      m_c2 = m_c1; m_c1 = code;
      m_i1 = m_i1 + longint'(xv) - lv;
      m_i2 = m_i2 + m_i1 - lv;
    end else begin
      eb = prev_bit;
      ew = prev_word;
    end
    @(posedge clk);
    @(negedge clk);
    if (cev) begin
      check(bit_o == eb[0], "R3 bit", longint'(bit_o), eb);
      check(longint'(word_o) == ew, "R4/R5 word", longint'(word_o), ew);
      comb = (bit_o ? LVL : -LVL) + longint'(word_o) * SCALE;
      s1 = s1 + (comb - xprev); s2 = s2 + s1; s3 = s3 + s2;
      xprev = longint'(xv);
      check(s3 <= 0 && s3 > -SCALE, "R8 cancellation", s3, 0);
    end else begin
      check(bit_o == eb[0] && longint'(word_o) == ew, "R2 hold", longint'(word_o), ew);
    end
    prev_bit = eb; prev_word = ew;
  endtask

  task automatic do_reset();
    rst = 1'b1; ce = 1'b1; x_i = 18'sd77777;
    @(posedge clk); @(negedge clk);
    check(bit_o == 1'b0 && word_o == '0, "R1 reset clear", longint'(word_o), 0);
    rst = 1'b0; ce = 1'b0;
    model_reset();
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    rst = 1'b1; ce = 1'b1;
    repeat (3) @(negedge clk);
    check(bit_o == 1'b0 && word_o == '0, "R1 reset clear", longint'(word_o), 0);
    rst = 1'b0; ce = 1'b0;

    // R6: first enabled output ignores the input being sampled
    step(131071, 1'b1);
    check(bit_o == 1'b1 && word_o == -8'sd2, "R6 first output", longint'(word_o), -2);

    for (int s = 0; s < SEG_N; s++) begin
      for (int k = 0; k < SEG_LEN[s]; k++) begin
        case (SEG_MOD[s])
          1: step((k % 2 == 1) ? -SEG_VAL[s] : SEG_VAL[s], 1'b1);
          2: step(-131072 + k * SEG_VAL[s], 1'b1);
          3: if (k % 3 == 2) step(-((k * 7919) % 131072), 1'b0); // R2 gap, junk input
             else step(SEG_VAL[s], 1'b1);
          default: step(SEG_VAL[s], 1'b1);
        endcase
      end
    end

    // R1: reset in the middle of a run with enable high
    do_reset();
    step(-131072, 1'b1);
    check(bit_o == 1'b1 && word_o == -8'sd2, "R6 first output after mid reset", longint'(word_o), -2);
    // R6: second output depends on the first sample
    step(0, 1'b1);
    // R2: long idle stretch with changing input, then resume
    for (int k = 0; k < 20; k++) step(131071 - k * 5000, 1'b0);
    for (int k = 0; k < 200; k++) step((k % 5 == 0) ? -131072 : 131071, 1'b1);
    // R7: sustained extreme inputs keep the loops in range (checked by the model match and R8)
    for (int k = 0; k < 300; k++) step(-131072, 1'b1);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule